// File: doc/BRIEF.md
# Look-Ahead Authenticated Cipher-Feedback Engine

This block runs a cipher-feedback mode in which the keystream for every transmission unit is settled a fixed number of units, T, before the unit arrives. Data moves in R-bit units, and a P-bit feedback register feeds an external block cipher through a valid/ready request and response pair. The feedback for unit i is taken from unit i-T, not from unit i-1. Up to T cipher requests can therefore be in flight at once, and a unit that arrives never waits for the cipher once the pipeline is primed. Each accepted unit appears on the output exactly one cycle after it is accepted.

A start pulse latches the IV, the message length n and the direction, and clears all state. The first T register values are IV+1 through IV+T. After those, each register value is the previous one shifted left by R bits, with the newest ciphertext unit filling the low end. The cipher input is that register value XORed with the plaintext unit from T positions earlier, with the plaintext placed in the high R bits. After the n message units, T indicator units follow, and each indicator encrypts an all-zero plaintext. On decryption the engine recovers every indicator. Any nonzero indicator raises an integrity-fail flag once the last unit has been processed.

Top module: `iapcfb_engine`

## Requirements
- R1: While reset is held, and after it is released, in_ready, out_valid, req_valid, done and integ_fail are all 0.
- R2: After start, the first T cipher requests carry IV+1, IV+2, …, IV+T in that order, counted modulo 2^P.
- R3: The request for unit i > T carries {X[P-R-1:0], C(i-T)} XOR {M(i-T), P-R zero bits}. Here X is the previous register value, C is the ciphertext and M is the plaintext. A request that is not yet accepted keeps its data stable.
- R4: An output unit is the high R bits of the cipher response XORed with the input unit: ciphertext on encrypt, plaintext on decrypt. It appears on out_data with out_valid exactly one cycle after the input handshake.
- R5: On encrypt (mode_dec=0 at start), after n units have been accepted the engine emits T indicator units on its own with plaintext taken as zero. in_ready stays 0 from then on.
- R6: On decrypt (mode_dec=1 at start), all n+T units are taken from the input. The feedback uses the received ciphertext and the recovered plaintext, so decrypting an untouched encrypted stream returns the original message and all-zero indicators.
- R7: integ_fail is 1 exactly when done is 1 on a decrypt run in which some recovered indicator unit was nonzero. Any change to a received unit sets it.
- R8: Requests issued minus responses accepted never exceeds T. rsp_ready is 0 only when T keystream units are already buffered.
- R9: A start pulse reloads IV, n and mode, and clears done and integ_fail on the next cycle.
- R10: done rises together with the output of unit n+T and stays high until the next start. in_ready is 0 while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a message |
| mode_dec | input | 1 | Direction sampled at start: 0 encrypt, 1 decrypt |
| iv | input | P | Initial value sampled at start |
| n_units | input | NW | Message length in units, sampled at start |
| in_valid | input | 1 | Input unit valid |
| in_data | input | R | Input unit: plaintext or ciphertext |
| in_ready | output | 1 | Engine can take an input unit this cycle |
| out_valid | output | 1 | Output unit valid for one cycle |
| out_data | output | R | Output unit |
| req_valid | output | 1 | Cipher request valid |
| req_data | output | P | Block presented to the cipher |
| req_ready | input | 1 | Cipher accepts the request |
| rsp_valid | input | 1 | Cipher response valid, in request order |
| rsp_data | input | P | Cipher output block |
| rsp_ready | output | 1 | Keystream buffer has room |
| done | output | 1 | All n+T units processed |
| integ_fail | output | 1 | Indicator mismatch, valid while done is high |

## Verification
The bench builds the engine with P=32, R=8, T=3 and NW=6. With these values a single register value holds four units, so the shifted-in ciphertext walks across the whole register within one message. A three-deep look-ahead lets the keystream buffer fill and empty under a cipher that stalls its request ready and answers late. Message lengths from 0 to 20 cover indicator-only streams and long chains of feedback. An IV close to all-ones checks the carry of the counter that seeds the first T registers. Single-unit tampering, both inside the message and on the last indicator, checks the single-pass integrity flag.

// File: rtl/iapcfb_engine.sv
module iapcfb_engine #(
  parameter int P  = 32,
  parameter int R  = 8,
  parameter int T  = 3,
  parameter int NW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_dec,
  input  logic [P-1:0]  iv,
  input  logic [NW-1:0] n_units,
  input  logic          in_valid,
  input  logic [R-1:0]  in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [R-1:0]  out_data,
  output logic          req_valid,
  output logic [P-1:0]  req_data,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic [P-1:0]  rsp_data,
  output logic          rsp_ready,
  output logic          done,
  output logic          integ_fail
);
  localparam int AW = (T > 1) ? $clog2(T) : 1;
  localparam int CW = $clog2(T + 1);
  localparam int IW = NW + CW;

  logic          busy, dec_r, fail_r;
  logic [NW-1:0] n_r;
  logic [P-1:0]  xreg;
  logic [IW-1:0] idx;
  logic [CW-1:0] icnt, kcnt;
  logic [AW-1:0] wp, rp;
  logic [R-1:0]  kbuf [T];

  logic          init_done, slot_ok, in_msg, need_in, go, fire, push, last_u, init_issue;
  logic [R-1:0]  ks, din, c_u, m_u;
  logic [P-1:0]  x_sh;

  assign init_done  = (icnt == CW'(T));
  assign slot_ok    = !req_valid || req_ready;
  assign in_msg     = idx < {{(IW-NW){1'b0}}, n_r};
  assign need_in    = dec_r || in_msg;
  assign go         = busy && init_done && (kcnt != '0) && slot_ok;
  assign in_ready   = go && need_in;
  assign fire       = go && (need_in ? in_valid : 1'b1);
  assign init_issue = busy && !init_done && slot_ok;
  assign last_u     = (idx + 1'b1) == ({{(IW-NW){1'b0}}, n_r} + IW'(T));

  assign ks   = kbuf[rp];
  assign din  = need_in ? in_data : '0;
  assign c_u  = dec_r ? din : (ks ^ din);
  assign m_u  = dec_r ? (ks ^ din) : din;
  assign x_sh = {xreg[P-R-1:0], c_u};

  assign rsp_ready  = (kcnt != CW'(T));
  assign push       = rsp_valid && rsp_ready;
  assign integ_fail = done && fail_r;

  always_ff @(posedge clk) begin
    if (push) kbuf[wp] <= rsp_data[P-1 -: R];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; dec_r <= 1'b0; fail_r <= 1'b0; n_r <= '0;
      xreg <= '0; idx <= '0; icnt <= '0; kcnt <= '0; wp <= '0; rp <= '0;
      req_valid <= 1'b0; req_data <= '0;
      out_valid <= 1'b0; out_data <= '0; done <= 1'b0;
    end else if (start) begin
      busy <= 1'b1; dec_r <= mode_dec; fail_r <= 1'b0; n_r <= n_units;
      xreg <= iv; idx <= '0; icnt <= '0; kcnt <= '0; wp <= '0; rp <= '0;
      req_valid <= 1'b0; out_valid <= 1'b0; done <= 1'b0;
    end else begin
      out_valid <= fire;
      kcnt <= kcnt + CW'(push) - CW'(fire);
      if (push) wp <= (wp == AW'(T-1)) ? '0 : wp + 1'b1;
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (init_issue) begin
        req_valid <= 1'b1;
        req_data  <= xreg + 1'b1;
        xreg      <= xreg + 1'b1;
        icnt      <= icnt + 1'b1;
      end
      if (fire) begin
        out_data <= dec_r ? m_u : c_u;
        xreg     <= x_sh;
        idx      <= idx + 1'b1;
        rp       <= (rp == AW'(T-1)) ? '0 : rp + 1'b1;
        if (in_msg) begin
          req_valid <= 1'b1;
          req_data  <= x_sh ^ {m_u, {(P-R){1'b0}}};
        end
        if (dec_r && !in_msg && (m_u != '0)) fail_r <= 1'b1;
        if (last_u) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/iapcfb_engine_chk.sv
module iapcfb_engine_chk #(
  parameter int P = 32,
  parameter int T = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         req_valid,
  input logic [P-1:0] req_data,
  input logic         req_ready,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic         done
);
  logic [7:0] outs;

  always_ff @(posedge clk) begin
    if (!rst_n) outs <= '0;
    else outs <= outs + 8'(req_valid && req_ready) - 8'(rsp_valid && rsp_ready);
  end

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !out_valid && !req_valid));

  // R4
  unit_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !start) |=> out_valid);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !start) |=> (req_valid && $stable(req_data)));

  // R8
  credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outs <= 8'(T));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R10
  no_in_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
endmodule

bind iapcfb_engine iapcfb_engine_chk #(.P(P), .T(T)) chk_i (.*);

// File: tb/iapcfb_engine_tb_top.sv
module iapcfb_engine_tb_top;
  localparam int P = 32, R = 8, T = 3, NW = 6, MX = 64;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_dec = 1'b0;
  logic [P-1:0] iv = '0;
  logic [NW-1:0] n_units = '0;
  logic in_valid = 1'b0;
  logic [R-1:0] in_data = '0;
  logic in_ready, out_valid, req_valid, req_ready, rsp_valid, rsp_ready, done, integ_fail;
  logic [R-1:0] out_data;
  logic [P-1:0] req_data, rsp_data;

  always #2 clk = ~clk;

  iapcfb_engine #(.P(P), .R(R), .T(T), .NW(NW)) dut_i (.*);

  int total = 0, bad = 0;

  function automatic logic [P-1:0] perm(input logic [P-1:0] v);
    logic [P-1:0] w;
    w = v ^ 32'h5ac3_17e9;
    w = {w[26:0], w[31:27]} + 32'h9e37_79b9;
    return w ^ (w >> 11);
  endfunction

  // cipher stand-in: in-order, variable latency, optional request stalls
  logic stall_en = 1'b0;
  int cyc = 0, cw_i = 0, cr_i = 0, rcnt = 0;
  logic [P-1:0] cq [0:15];
  int cst [0:15];
  logic [P-1:0] rlog [0:MX-1];
  assign req_ready = !stall_en || (cyc % 3 != 0);
  assign rsp_valid = (cw_i != cr_i) && (cyc >= cst[cr_i % 16]);
  assign rsp_data  = cq[cr_i % 16];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (req_valid && req_ready) begin
      cq[cw_i % 16]  <= perm(req_data);
      cst[cw_i % 16] <= cyc + (stall_en ? 5 : 1);
      cw_i <= cw_i + 1;
      rlog[rcnt % MX] <= req_data;
      rcnt <= rcnt + 1;
    end
    if (rsp_valid && rsp_ready) cr_i <= cr_i + 1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [R-1:0] msg [0:MX-1], src [0:MX-1], cexp [0:MX-1], got [0:MX-1];
  logic [P-1:0] bexp [0:MX-1];
  logic efail;
  int gcnt;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (out_valid && gcnt < MX) begin got[gcnt] = out_data; gcnt++; end
  endtask

  // model written from the requirements
  task automatic ref_run(input logic dec, input logic [P-1:0] ivv, input int nn);
    logic [P-1:0] x, blk, o;
    logic [R-1:0] ks, c, m;
    logic [R-1:0] cs [0:MX-1];
    logic [R-1:0] ms [0:MX-1];
    x = ivv; efail = 1'b0;
    for (int i = 0; i < nn + T; i++) begin
      if (i < T) begin x = ivv + P'(i + 1); blk = x; end
      else begin
        x = {x[P-R-1:0], cs[i-T]};
        blk = x ^ {ms[i-T], {(P-R){1'b0}}};
      end
      bexp[i] = blk;
      o = perm(blk);
      ks = o[P-1 -: R];
      if (!dec) begin m = (i < nn) ? src[i] : '0; c = ks ^ m; cexp[i] = c; end
      else begin c = src[i]; m = ks ^ c; cexp[i] = m; if (i >= nn && m != '0) efail = 1'b1; end
      cs[i] = c; ms[i] = m;
    end
  endtask

  task automatic send(input logic [R-1:0] d);
    logic acc;
    in_valid = 1'b1; in_data = d; acc = 1'b0;
    while (!acc) begin acc = in_ready; step(); end
    chk(out_valid === 1'b1, "R4 latency", out_valid, 1);
    in_valid = 1'b0;
  endtask

  task automatic run(input logic dec, input logic [P-1:0] ivv, input int nn);
    int rbase, feed, lim;
    ref_run(dec, ivv, nn);
    rbase = rcnt;
    start = 1'b1; mode_dec = dec; iv = ivv; n_units = NW'(nn);
    step();
    start = 1'b0; gcnt = 0;
    chk(done === 1'b0 && integ_fail === 1'b0, "R9 start clears", {done, integ_fail}, 0);
    feed = dec ? nn + T : nn;
    for (int i = 0; i < feed; i++) send(src[i]);
    lim = 0;
    while (!done && lim < 2000) begin
      chk(in_ready === 1'b0, "R5 no input taken", in_ready, 0);
      step(); lim++;
    end
    chk(done === 1'b1, "R10 done", done, 1);
    chk(gcnt == nn + T, "R10 unit count", gcnt, nn + T);
    for (int i = 0; i < nn + T; i++)
      chk(got[i] === cexp[i], dec ? "R6 recovered unit" : "R4 cipher unit", got[i], cexp[i]);
    for (int i = 0; i < nn + T; i++)
      chk(rlog[(rbase + i) % MX] === bexp[i], (i < T) ? "R2 seed request" : "R3 feedback request",
          rlog[(rbase + i) % MX], bexp[i]);
    chk(integ_fail === efail, "R7 integrity flag", integ_fail, efail);
    chk(rcnt - rbase == nn + T, "R8 request count", rcnt - rbase, nn + T);
  endtask

  typedef struct packed {
    logic [P-1:0] iv;
    logic [5:0]   n;
    logic [7:0]   seed;
    logic         stall;
  } vec_t;

  localparam vec_t VT [5] = '{
    '{iv: 32'h1234_5678, n: 6'd6,  seed: 8'h3b, stall: 1'b0},
    '{iv: 32'h0000_0000, n: 6'd1,  seed: 8'h91, stall: 1'b1},
    '{iv: 32'hdead_beef, n: 6'd0,  seed: 8'h00, stall: 1'b0},
    '{iv: 32'h0f0f_a5a5, n: 6'd20, seed: 8'h6d, stall: 1'b1},
    '{iv: 32'hffff_fffe, n: 6'd4,  seed: 8'hc4, stall: 1'b0}
  };

  initial begin
    gcnt = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({in_ready, out_valid, req_valid, done, integ_fail} === 5'b0, "R1 in reset",
        {in_ready, out_valid, req_valid, done, integ_fail}, 0);
    rst_n = 1'b1;
    step();
    chk({in_ready, out_valid, req_valid, done, integ_fail} === 5'b0, "R1 after reset",
        {in_ready, out_valid, req_valid, done, integ_fail}, 0);

    foreach (VT[v]) begin
      int nn;
      nn = int'(VT[v].n);
      stall_en = VT[v].stall;
      for (int i = 0; i < nn; i++) msg[i] = R'(VT[v].seed * (i + 3)) ^ R'(i << 4);
      for (int i = 0; i < nn; i++) src[i] = msg[i];
      run(1'b0, VT[v].iv, nn);
      for (int i = 0; i < nn + T; i++) src[i] = got[i];
      run(1'b1, VT[v].iv, nn);
      for (int i = 0; i < nn; i++)
        chk(got[i] === msg[i], "R6 round trip", got[i], msg[i]);
      chk(integ_fail === 1'b0, "R7 clean stream", integ_fail, 0);
    end

    // tamper a message unit, then the last indicator
    stall_en = 1'b0;
    for (int i = 0; i < 8; i++) msg[i] = R'(8'h21 + i * 7);
    for (int i = 0; i < 8; i++) src[i] = msg[i];
    run(1'b0, 32'h0bad_cafe, 8);
    for (int i = 0; i < 8 + T; i++) src[i] = got[i];
    src[2] = src[2] ^ 8'h10;
    run(1'b1, 32'h0bad_cafe, 8);
    chk(integ_fail === 1'b1, "R7 tampered message", integ_fail, 1);
    src[2] = src[2] ^ 8'h10;
    src[8 + T - 1] = src[8 + T - 1] ^ 8'h01;
    run(1'b1, 32'h0bad_cafe, 8);
    chk(integ_fail === 1'b1, "R7 tampered indicator", integ_fail, 1);
    src[8 + T - 1] = src[8 + T - 1] ^ 8'h01;
    run(1'b1, 32'h0bad_cafe, 8);
    chk(integ_fail === 1'b0, "R9 flag cleared on restart", integ_fail, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule